// File: doc/BRIEF.md
# Extended 32-bit Integer ALU

This block is the arithmetic-logic unit of a small single-cycle RISC core. It takes two 32-bit operands and a 4-bit operation code from the ALU decoder. It returns a 32-bit result and a flag that is high when that result is zero. The unit is purely combinational, with no clock, no reset and no handshake. The result follows the inputs within the same cycle, and the surrounding datapath registers it wherever it needs to.

The operation set has several parts:
- wrapping addition and subtraction;
- logical shifts in both directions, with the amount taken from the low bits of the second operand;
- five bitwise operations: AND, OR, XOR, NOR and NAND;
- a signed less-than and a signed greater-than comparison;
- a pass-through of the first operand, which the core uses for jump-register;
- codes 12 to 15, which are unused and give a zero result.

Top module: `ext_alu`

## Requirements
- R1: Code 0 gives `opnd_a + opnd_b` modulo 2^32; the carry out is discarded.
- R2: Code 1 gives `opnd_a - opnd_b` modulo 2^32.
- R3: Code 2 shifts `opnd_a` left by `opnd_b[4:0]` and fills with zeros. Bits 31:5 of `opnd_b` have no effect.
- R4: Code 3 shifts `opnd_a` right by `opnd_b[4:0]` and fills with zeros, not with the sign bit. Bits 31:5 of `opnd_b` have no effect.
- R5: Code 4 gives bitwise AND, code 5 gives bitwise OR, and code 6 gives bitwise XOR of the operands.
- R6: Code 7 gives bitwise NOR and code 8 gives bitwise NAND of the operands.
- R7: Code 9 gives 1 when `opnd_a` is less than `opnd_b` as two's-complement numbers, and 0 otherwise. Bits 31:1 of the result are zero.
- R8: Code 10 gives 1 when `opnd_a` is strictly greater than `opnd_b` as two's-complement numbers, and 0 otherwise. Equal operands give 0, and bits 31:1 of the result are zero.
- R9: Code 11 passes `opnd_a` through to the result unchanged, whatever the value of `opnd_b`.
- R10: Codes 12, 13, 14 and 15 give a result of zero.
- R11: `is_zero` is 1 exactly when all 32 bits of `result` are zero, for every code.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opnd_a | input | 32 | First operand; the shift source and the pass-through value |
| opnd_b | input | 32 | Second operand; its low 5 bits give the shift amount |
| op_sel | input | 4 | Operation code, 0 to 15 |
| result | output | 32 | Result of the selected operation |
| is_zero | output | 1 | High when `result` is zero |

## Verification
The bench aims at several corner cases where a plausible slip would show:
- **Comparisons near the sign boundary.** It pairs the most positive and most negative values, and also pairs -1 with 1. A design that compared the operands as unsigned numbers would report the opposite ordering.
- **Equal operands under greater-than.** A design that built greater-than as the inverse of less-than would return 1 here instead of 0.
- **Large shift amounts.** Amounts of 31 and 32 or more catch a design that shifts by all of `opnd_b` or fills a right shift with the sign bit.
- **Wrap-around, pass-through and unused codes.** Addition that wraps to zero checks the zero flag. The pass-through is driven with a changing second operand, and the unused codes with non-zero operands, so that any leakage into the result shows.

// File: rtl/ext_alu_pkg.sv
package ext_alu_pkg;
  localparam int OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_SLL  = 4'd2,
    OP_SRL  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_NOR  = 4'd7,
    OP_NAND = 4'd8,
    OP_SLT  = 4'd9,
    OP_SGT  = 4'd10,
    OP_JR   = 4'd11
  } alu_op_e;
endpackage

// File: rtl/ext_alu_addsub.sv
module ext_alu_addsub #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] sum,
  output logic [W-1:0] diff,
  output logic         lt,
  output logic         gt
);
  localparam int MSB = W - 1;

  logic [W-1:0] b_inv;
  logic         ovf;
  logic         eq;

  assign sum   = a + b;
  assign b_inv = ~b;
  // subtraction as a + ~b + 1
  assign diff  = a + b_inv + {{(W-1){1'b0}}, 1'b1};

  // signed overflow of the subtraction: operand signs differ and the
  // difference sign departs from a
  assign ovf = (a[MSB] ^ b[MSB]) & (diff[MSB] ^ a[MSB]);
  assign eq  = (diff == '0);
  assign lt  = diff[MSB] ^ ovf;
  assign gt  = ~lt & ~eq;
endmodule

// File: rtl/ext_alu_shift.sv
module ext_alu_shift #(
  parameter int W    = 32,
  parameter bit LEFT = 1'b1
) (
  input  logic [W-1:0]         din,
  input  logic [$clog2(W)-1:0] amt,
  output logic [W-1:0]         dout
);
  localparam int SHW = $clog2(W);

  logic [W-1:0] stg [0:SHW];

  assign stg[0] = din;

  // one stage per amount bit, stage i moves by 2**i places
  for (genvar i = 0; i < SHW; i++) begin : g_stage
    if (LEFT) begin : g_left
      assign stg[i+1] = amt[i] ? (stg[i] << (1 << i)) : stg[i];
    end else begin : g_right
      assign stg[i+1] = amt[i] ? (stg[i] >> (1 << i)) : stg[i];
    end
  end

  assign dout = stg[SHW];
endmodule

// File: rtl/ext_alu_logic.sv
module ext_alu_logic #(
  parameter int W = 32
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] y_and,
  output logic [W-1:0] y_or,
  output logic [W-1:0] y_xor,
  output logic [W-1:0] y_nor,
  output logic [W-1:0] y_nand
);
  assign y_and  = a & b;
  assign y_or   = a | b;
  assign y_xor  = a ^ b;
  assign y_nor  = ~y_or;
  assign y_nand = ~y_and;
endmodule

// File: rtl/ext_alu.sv
module ext_alu
  import ext_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] opnd_a,
  input  logic [WIDTH-1:0] opnd_b,
  input  logic [OPW-1:0]   op_sel,
  output logic [WIDTH-1:0] result,
  output logic             is_zero
);
  localparam int SHW = $clog2(WIDTH);

  logic [WIDTH-1:0] sum_w, diff_w, shl_w, shr_w;
  logic [WIDTH-1:0] and_w, or_w, xor_w, nor_w, nand_w;
  logic             lt_w, gt_w;
  logic [SHW-1:0]   amt_w;

  assign amt_w = opnd_b[SHW-1:0];

  ext_alu_addsub #(.W(WIDTH)) u_addsub (
    .a(opnd_a), .b(opnd_b), .sum(sum_w), .diff(diff_w), .lt(lt_w), .gt(gt_w)
  );

  ext_alu_shift #(.W(WIDTH), .LEFT(1'b1)) u_shl (
    .din(opnd_a), .amt(amt_w), .dout(shl_w)
  );

  ext_alu_shift #(.W(WIDTH), .LEFT(1'b0)) u_shr (
    .din(opnd_a), .amt(amt_w), .dout(shr_w)
  );

  ext_alu_logic #(.W(WIDTH)) u_logic (
    .a(opnd_a), .b(opnd_b), .y_and(and_w), .y_or(or_w), .y_xor(xor_w),
    .y_nor(nor_w), .y_nand(nand_w)
  );

  always_comb begin
    case (op_sel)
      OP_ADD:  result = sum_w;
      OP_SUB:  result = diff_w;
      OP_SLL:  result = shl_w;
      OP_SRL:  result = shr_w;
      OP_AND:  result = and_w;
      OP_OR:   result = or_w;
      OP_XOR:  result = xor_w;
      OP_NOR:  result = nor_w;
      OP_NAND: result = nand_w;
      OP_SLT:  result = {{(WIDTH-1){1'b0}}, lt_w};
      OP_SGT:  result = {{(WIDTH-1){1'b0}}, gt_w};
      OP_JR:   result = opnd_a;
      default: result = '0;
    endcase
  end

  assign is_zero = ~|result;
endmodule

// File: rtl/ext_alu_chk.sv
module ext_alu_chk
  import ext_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input logic [WIDTH-1:0] opnd_a,
  input logic [WIDTH-1:0] opnd_b,
  input logic [OPW-1:0]   op_sel,
  input logic [WIDTH-1:0] result,
  input logic             is_zero
);
  always_comb begin
    AST_ZERO_FLAG: assert (is_zero == (result == '0)) else $error("zero flag mismatch"); // R11
    if (op_sel == OP_JR)
      AST_JR_PASS: assert (result == opnd_a) else $error("jr pass-through"); // R9
    if (op_sel >= 4'd12)
      AST_UNUSED_ZERO: assert (result == '0) else $error("unused code nonzero"); // R10
    if (op_sel == OP_ADD)
      AST_ADD_WRAP: assert (result == opnd_a + opnd_b) else $error("add"); // R1
    if (op_sel == OP_SLT)
      AST_SLT_SIGNED: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opnd_a) < $signed(opnd_b))})
        else $error("slt"); // R7
    if (op_sel == OP_SGT)
      AST_SGT_SIGNED: assert (result == {{(WIDTH-1){1'b0}}, ($signed(opnd_a) > $signed(opnd_b))})
        else $error("sgt"); // R8
  end
endmodule

bind ext_alu ext_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .result(result), .is_zero(is_zero)
);

// File: tb/ext_alu_bench.sv
module ext_alu_bench;
  logic        clk = 1'b0;
  logic [31:0] opnd_a = '0;
  logic [31:0] opnd_b = '0;
  logic [3:0]  op_sel = '0;
  logic [31:0] result;
  logic        is_zero;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  ext_alu u_ext_alu (
    .opnd_a(opnd_a), .opnd_b(opnd_b), .op_sel(op_sel), .result(result), .is_zero(is_zero)
  );

  function automatic logic [31:0] model(input logic [31:0] a, input logic [31:0] b,
                                        input logic [3:0] op);
    case (op)
      4'd0:  return a + b;
      4'd1:  return a - b;
      4'd2:  return a << b[4:0];
      4'd3:  return a >> b[4:0];
      4'd4:  return a & b;
      4'd5:  return a | b;
      4'd6:  return a ^ b;
      4'd7:  return ~(a | b);
      4'd8:  return ~(a & b);
      4'd9:  return {31'd0, $signed(a) < $signed(b)};
      4'd10: return {31'd0, $signed(a) > $signed(b)};
      4'd11: return a;
      default: return 32'd0;
    endcase
  endfunction

  function automatic string tag_of(input logic [3:0] op);
    case (op)
      4'd0: return "R1";
      4'd1: return "R2";
      4'd2: return "R3";
      4'd3: return "R4";
      4'd4, 4'd5, 4'd6: return "R5";
      4'd7, 4'd8: return "R6";
      4'd9: return "R7";
      4'd10: return "R8";
      4'd11: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic apply(input logic [31:0] a, input logic [31:0] b, input logic [3:0] op);
    logic [31:0] exp;
    @(negedge clk);
    opnd_a = a; opnd_b = b; op_sel = op;
    @(posedge clk); #1;
    exp = model(a, b, op);
    n_chk++;
    if (result !== exp) begin
      n_fail++;
      $display("FAIL %s op=%0d a=%h b=%h result=%h expected=%h", tag_of(op), op, a, b, result, exp);
    end
    n_chk++;
    if (is_zero !== (exp == 32'd0)) begin
      n_fail++;
      $display("FAIL R11 op=%0d is_zero=%b expected=%b", op, is_zero, exp == 32'd0);
    end
  endtask

  initial begin
    int unused_seed;
    unused_seed = $urandom(32'd1234);
    // initial all-zero inputs: add of zeros yields zero, flag high (R1, R11)
    apply(32'h0, 32'h0, 4'd0);
    // R1 wrap to zero
    apply(32'hFFFF_FFFF, 32'h1, 4'd0);
    // R2 borrow wrap
    apply(32'h0, 32'h1, 4'd1);
    apply(32'h1234_5678, 32'h1234_5678, 4'd1);
    // R3 upper bits of b ignored, shift by 32+1 acts as 1
    apply(32'h8000_0001, 32'h0000_0021, 4'd2);
    apply(32'h0000_0001, 32'hFFFF_FFE0, 4'd2);
    apply(32'h0000_0001, 32'd31, 4'd2);
    // R4 zero fill, not sign fill
    apply(32'h8000_0000, 32'd31, 4'd3);
    apply(32'hF000_0000, 32'h0000_0024, 4'd3);
    // R5, R6 bitwise
    apply(32'hF0F0_A5A5, 32'hFF00_5A5A, 4'd4);
    apply(32'hF0F0_A5A5, 32'hFF00_5A5A, 4'd5);
    apply(32'hF0F0_A5A5, 32'hFF00_5A5A, 4'd6);
    apply(32'h0, 32'h0, 4'd7);
    apply(32'hFFFF_FFFF, 32'hFFFF_FFFF, 4'd8);
    // R7 sign boundary
    apply(32'hFFFF_FFFF, 32'h1, 4'd9);
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'd9);
    apply(32'h5, 32'h5, 4'd9);
    // R8 sign boundary and equality
    apply(32'h7FFF_FFFF, 32'h8000_0000, 4'd10);
    apply(32'h8000_0000, 32'h7FFF_FFFF, 4'd10);
    apply(32'hDEAD_BEEF, 32'hDEAD_BEEF, 4'd10);
    // R9 pass-through with changing b
    apply(32'hCAFE_0042, 32'h0, 4'd11);
    apply(32'hCAFE_0042, 32'hFFFF_FFFF, 4'd11);
    apply(32'h0, 32'h1234_5678, 4'd11);
    // R10 unused codes with nonzero operands
    for (int c = 12; c < 16; c++) apply(32'hFFFF_FFFF, 32'hA5A5_A5A5, 4'(c));
    // constrained random across all codes
    for (int i = 0; i < 3000; i++) begin
      logic [31:0] ra, rb;
      ra = $urandom;
      rb = $urandom;
      if (i % 5 == 0) rb = ra;                 // equal operands
      if (i % 7 == 0) ra = {ra[31], 31'h0};    // sign extremes
      apply(ra, rb, 4'($urandom_range(0, 15)));
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule